// File: doc/BRIEF.md
# Backlight Mailbox Command Sequencer

This block sits on the host side of a mailbox shared with an embedded brightness controller. It turns one request (set the adaptive-brightness level, disable adaptive brightness at once, or set the backlight with a frame ramp) into an ordered series of single-cycle write strobes. The strobes go to a command register, a data register, a user-level register and a strobe that raises the shared interrupt flag. The controller clears that flag once it has taken a message. The sequencer watches the flag as a status input and counts how many cycles it stays up.

A request is taken when `req_valid_i` is high and `busy_o` is low. The sequencer then steps through its sequence and returns to idle. While the flag is up it polls once per cycle. If the flag stays up for `POLL_LIMIT` consecutive polls, the sequence is cut short, a sticky error flag is set and the sequencer goes back to idle.

Top module: `mbox_seq`

## Requirements
- R1: After reset `busy_o` and `err_o` are low and none of `cmd_we_o`, `data_we_o`, `lvl_we_o`, `flag_set_o` is asserted.
- R2: A level request (`req_kind_i` = 0) first waits until `flag_i` is low. It then writes a command word with opcode 0x65 in bits [7:0], zero in bits [15:8], the level in bits [23:16] and zero above, and follows with one `flag_set_o` strobe.
- R3: A disable request (`req_kind_i` = 1) behaves as R2, except that bits [23:16] are 0xFF whatever `req_level_i` holds.
- R4: A backlight request (`req_kind_i` = 2) strobes in this order: data 0xFFFF; command with opcode 0x66 and the pipe id in bits [15:8]; a flag raise; a wait for the flag to clear; the user-level write; the ramp on the data register; command with opcode 0x67 and the pipe id in bits [15:8]; a flag raise; and a final wait.
- R5: The user-level value is the 8-bit level L widened to 17 bits as {L,L} + L[7] (0xEF gives 0xEFF0, 0xFF gives 0x10000, 0x00 gives 0).
- R6: The ramp written to the data register is 0 when the pipe id is 0, and `req_ramp_i` otherwise.
- R7: At most one strobe is active in any cycle, and a level or disable command is never written in a cycle that follows one in which `flag_i` was high.
- R8: If `flag_i` stays high for `POLL_LIMIT` consecutive polled cycles in any wait, no further strobe is issued and the sequencer returns to idle.
- R9: `err_o` rises on a timeout and stays high until reset.
- R10: `busy_o` is high from the cycle after a request is accepted until the return to idle. Requests arriving while busy, and requests with `req_kind_i` = 3, produce no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 2 | 0 level, 1 disable, 2 backlight, 3 reserved |
| req_level_i | input | 8 | Adaptive-brightness level for kind 0 |
| req_pipe_i | input | 8 | Pipe / controller id for kind 2 |
| req_bl_i | input | 8 | 8-bit backlight level for kind 2 |
| req_ramp_i | input | DATA_W | Frame ramp for kind 2 |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Sticky timeout error |
| flag_i | input | 1 | Mailbox interrupt flag as seen by the host |
| flag_set_o | output | 1 | Strobe that raises the interrupt flag |
| cmd_we_o | output | 1 | Command register write strobe |
| cmd_wdata_o | output | DATA_W | Command word |
| data_we_o | output | 1 | Data register write strobe |
| data_wdata_o | output | DATA_W | Data word |
| lvl_we_o | output | 1 | User-level register write strobe |
| lvl_wdata_o | output | 17 | 17-bit user level |

## Verification
The bench targets the level-widening corners 0x00, 0x80, 0xEF and 0xFF. A wrong rounding term would give 0xEFEF or 0xFFFF instead of 0xEFF0 or 0x10000. A pipe-0 backlight request with a non-zero ramp catches a design that forgets to force the ramp to zero. A level request issued while the flag is already up shows whether the pre-write wait exists: without it, the command lands while the flag is high. A flag that never clears, tested once in a backlight wait and once in a pre-write wait, shows whether the abort happens after exactly `POLL_LIMIT` polls, issues no further strobes and leaves the error bit set through later successful requests. Requests made while busy, and requests of the reserved kind, must add no strobes to the scoreboard.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BYTE_W = 8;
  localparam int ULVL_W = 17;

  localparam logic [7:0]  OP_SET_LEVEL = 8'h65;
  localparam logic [7:0]  OP_SET_PIPE  = 8'h66;
  localparam logic [7:0]  OP_SET_BL    = 8'h67;
  localparam logic [7:0]  LEVEL_OFF    = 8'hFF;
  localparam logic [15:0] RAMP_BOUND   = 16'hFFFF;

  typedef enum logic [1:0] {
    K_LEVEL     = 2'd0,
    K_DISABLE   = 2'd1,
    K_BACKLIGHT = 2'd2,
    K_RSVD      = 2'd3
  } req_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_WAIT,
    ST_LVL_CMD,
    ST_LVL_RAISE,
    ST_BOUND,
    ST_PIPE_CMD,
    ST_PIPE_RAISE,
    ST_PIPE_WAIT,
    ST_USER_LVL,
    ST_RAMP,
    ST_BL_CMD,
    ST_BL_RAISE,
    ST_BL_WAIT
  } seq_state_e;

  // 8-bit level to unsigned 1.16, scaled by 256/255 with rounding
  function automatic logic [ULVL_W-1:0] widen_level(input logic [BYTE_W-1:0] lvl);
    return {1'b0, lvl, lvl} + ULVL_W'(lvl[BYTE_W-1]);
  endfunction
endpackage

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int LIMIT = 80000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic flag_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             polling;

  assign polling   = run_i && flag_i;
  assign expired_o = polling && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!polling)  cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mbox_fsm.sv
module mbox_fsm
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [BYTE_W-1:0] req_level_i,
  input  logic [BYTE_W-1:0] req_pipe_i,
  input  logic [BYTE_W-1:0] req_bl_i,
  input  logic [DATA_W-1:0] req_ramp_i,
  input  logic              flag_i,
  input  logic              expired_i,
  output seq_state_e        state_o,
  output logic              wait_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [BYTE_W-1:0] level_o,
  output logic [BYTE_W-1:0] pipe_o,
  output logic [BYTE_W-1:0] bl_o,
  output logic [DATA_W-1:0] ramp_o
);
  seq_state_e state_q, state_d;
  req_kind_e  kind;
  logic       accept;
  logic       err_q;
  logic [BYTE_W-1:0] level_q, pipe_q, bl_q;
  logic [DATA_W-1:0] ramp_q;

  assign kind   = req_kind_e'(req_kind_i);
  assign accept = (state_q == ST_IDLE) && req_valid_i && (kind != K_RSVD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (accept) state_d = (kind == K_BACKLIGHT) ? ST_BOUND : ST_PRE_WAIT;
      ST_PRE_WAIT:   if (!flag_i) state_d = ST_LVL_CMD;
                     else if (expired_i) state_d = ST_IDLE;
      ST_LVL_CMD:    state_d = ST_LVL_RAISE;
      ST_LVL_RAISE:  state_d = ST_IDLE;
      ST_BOUND:      state_d = ST_PIPE_CMD;
      ST_PIPE_CMD:   state_d = ST_PIPE_RAISE;
      ST_PIPE_RAISE: state_d = ST_PIPE_WAIT;
      ST_PIPE_WAIT:  if (!flag_i) state_d = ST_USER_LVL;
                     else if (expired_i) state_d = ST_IDLE;
      ST_USER_LVL:   state_d = ST_RAMP;
      ST_RAMP:       state_d = ST_BL_CMD;
      ST_BL_CMD:     state_d = ST_BL_RAISE;
      ST_BL_RAISE:   state_d = ST_BL_WAIT;
      ST_BL_WAIT:    if (!flag_i || expired_i) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      level_q <= '0;
      pipe_q  <= '0;
      bl_q    <= '0;
      ramp_q  <= '0;
    end else begin
      state_q <= state_d;
      if (expired_i) err_q <= 1'b1;
      if (accept) begin
        level_q <= (kind == K_DISABLE) ? LEVEL_OFF : req_level_i;
        pipe_q  <= req_pipe_i;
        bl_q    <= req_bl_i;
        ramp_q  <= req_ramp_i;
      end
    end
  end

  assign state_o = state_q;
  assign wait_o  = (state_q == ST_PRE_WAIT) || (state_q == ST_PIPE_WAIT) ||
                   (state_q == ST_BL_WAIT);
  assign busy_o  = (state_q != ST_IDLE);
  assign err_o   = err_q;
  assign level_o = level_q;
  assign pipe_o  = pipe_q;
  assign bl_o    = bl_q;
  assign ramp_o  = ramp_q;
endmodule

// File: rtl/mbox_word_fmt.sv
module mbox_word_fmt
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  seq_state_e        state_i,
  input  logic [BYTE_W-1:0] level_i,
  input  logic [BYTE_W-1:0] pipe_i,
  input  logic [BYTE_W-1:0] bl_i,
  input  logic [DATA_W-1:0] ramp_i,
  output logic              flag_set_o,
  output logic              cmd_we_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  output logic              data_we_o,
  output logic [DATA_W-1:0] data_wdata_o,
  output logic              lvl_we_o,
  output logic [ULVL_W-1:0] lvl_wdata_o
);
  always_comb begin
    flag_set_o   = 1'b0;
    cmd_we_o     = 1'b0;
    cmd_wdata_o  = '0;
    data_we_o    = 1'b0;
    data_wdata_o = '0;
    lvl_we_o     = 1'b0;
    lvl_wdata_o  = '0;
    unique case (state_i)
      ST_LVL_CMD: begin
        cmd_we_o    = 1'b1;
        cmd_wdata_o = DATA_W'({level_i, 8'h00, OP_SET_LEVEL});
      end
      ST_BOUND: begin
        data_we_o    = 1'b1;
        data_wdata_o = DATA_W'(RAMP_BOUND);
      end
      ST_PIPE_CMD: begin
        cmd_we_o    = 1'b1;
        cmd_wdata_o = DATA_W'({8'h00, pipe_i, OP_SET_PIPE});
      end
      ST_USER_LVL: begin
        lvl_we_o    = 1'b1;
        lvl_wdata_o = widen_level(bl_i);
      end
      ST_RAMP: begin
        data_we_o    = 1'b1;
        data_wdata_o = (pipe_i == '0) ? '0 : ramp_i;
      end
      ST_BL_CMD: begin
        cmd_we_o    = 1'b1;
        cmd_wdata_o = DATA_W'({8'h00, pipe_i, OP_SET_BL});
      end
      ST_LVL_RAISE, ST_PIPE_RAISE, ST_BL_RAISE: flag_set_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int POLL_LIMIT = 80000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [7:0]        req_level_i,
  input  logic [7:0]        req_pipe_i,
  input  logic [7:0]        req_bl_i,
  input  logic [DATA_W-1:0] req_ramp_i,
  output logic              busy_o,
  output logic              err_o,
  input  logic              flag_i,
  output logic              flag_set_o,
  output logic              cmd_we_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  output logic              data_we_o,
  output logic [DATA_W-1:0] data_wdata_o,
  output logic              lvl_we_o,
  output logic [16:0]       lvl_wdata_o
);
  seq_state_e        state;
  logic              waiting, expired;
  logic [BYTE_W-1:0] level_q, pipe_q, bl_q;
  logic [DATA_W-1:0] ramp_q;

  mbox_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .req_level_i (req_level_i),
    .req_pipe_i  (req_pipe_i),
    .req_bl_i    (req_bl_i),
    .req_ramp_i  (req_ramp_i),
    .flag_i      (flag_i),
    .expired_i   (expired),
    .state_o     (state),
    .wait_o      (waiting),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .level_o     (level_q),
    .pipe_o      (pipe_q),
    .bl_o        (bl_q),
    .ramp_o      (ramp_q)
  );

  mbox_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (waiting),
    .flag_i    (flag_i),
    .expired_o (expired)
  );

  mbox_word_fmt #(.DATA_W(DATA_W)) u_fmt (
    .state_i      (state),
    .level_i      (level_q),
    .pipe_i       (pipe_q),
    .bl_i         (bl_q),
    .ramp_i       (ramp_q),
    .flag_set_o   (flag_set_o),
    .cmd_we_o     (cmd_we_o),
    .cmd_wdata_o  (cmd_wdata_o),
    .data_we_o    (data_we_o),
    .data_wdata_o (data_wdata_o),
    .lvl_we_o     (lvl_we_o),
    .lvl_wdata_o  (lvl_wdata_o)
  );
endmodule

// File: rtl/mbox_seq_chk.sv
module mbox_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [1:0] req_kind_i,
  input logic       busy_o,
  input logic       err_o,
  input logic       flag_i,
  input logic       flag_set_o,
  input logic       cmd_we_o,
  input logic [7:0] cmd_op_i,
  input logic       data_we_o,
  input logic       lvl_we_o
);
  // R7: strobes are mutually exclusive
  a_r7_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_we_o, data_we_o, lvl_we_o, flag_set_o}));

  // R7 / R2: level command only after the flag was seen clear
  a_r7_no_cmd_over_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_o && cmd_op_i == 8'h65) |-> !$past(flag_i));

  // R2 / R4: every command write is followed by a flag raise
  a_r4_raise_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_o |=> flag_set_o);

  // R10: accepted request makes the block busy
  a_r10_busy_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && req_kind_i != 2'd3) |=> busy_o);

  // R10: reserved kind from idle is ignored
  a_r10_rsvd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && req_kind_i == 2'd3) |=> !busy_o);

  // R9: error is sticky
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R8: timeout returns to idle
  a_r8_idle_on_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o);
endmodule

bind mbox_seq mbox_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_kind_i  (req_kind_i),
  .busy_o      (busy_o),
  .err_o       (err_o),
  .flag_i      (flag_i),
  .flag_set_o  (flag_set_o),
  .cmd_we_o    (cmd_we_o),
  .cmd_op_i    (cmd_wdata_o[7:0]),
  .data_we_o   (data_we_o),
  .lvl_we_o    (lvl_we_o)
);

// File: tb/mbox_seq_tb.sv
module mbox_seq_tb;
  localparam int DATA_W = 32;
  localparam int LIMIT  = 40;
  localparam int T_CMD = 1, T_DATA = 2, T_LVL = 3, T_RAISE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [7:0] req_level = '0, req_pipe = '0, req_bl = '0;
  logic [DATA_W-1:0] req_ramp = '0;
  logic busy, err, flag, flag_set, cmd_we, data_we, lvl_we;
  logic [DATA_W-1:0] cmd_wdata, data_wdata;
  logic [16:0] lvl_wdata;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int hold_len = 4, hold_cnt = 0;
  bit stuck = 0, poke = 0;

  logic [35:0] exp_q[$];
  string       req_q[$];

  always #5 clk = ~clk;

  mbox_seq #(.DATA_W(DATA_W), .POLL_LIMIT(LIMIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_level_i(req_level), .req_pipe_i(req_pipe), .req_bl_i(req_bl),
    .req_ramp_i(req_ramp), .busy_o(busy), .err_o(err), .flag_i(flag),
    .flag_set_o(flag_set), .cmd_we_o(cmd_we), .cmd_wdata_o(cmd_wdata),
    .data_we_o(data_we), .data_wdata_o(data_wdata), .lvl_we_o(lvl_we),
    .lvl_wdata_o(lvl_wdata)
  );

  // controller model: flag rises on a raise strobe, clears after hold_len cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0; hold_cnt <= 0;
    end else if (flag_set || poke) begin
      flag <= 1'b1; hold_cnt <= hold_len;
    end else if (flag && !stuck) begin
      if (hold_cnt == 0) flag <= 1'b0;
      else hold_cnt <= hold_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string msg,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s act=%0h exp=%0h", req, msg, act, exp);
    end
  endtask

  task automatic push(input int tag, input logic [31:0] val, input string req);
    exp_q.push_back({4'(tag), val});
    req_q.push_back(req);
  endtask

  task automatic observe(input int tag, input logic [31:0] val);
    logic [35:0] got, want;
    string r;
    got = {4'(tag), val};
    if (exp_q.size() == 0) begin
      chk(1'b0, "R10", "unexpected strobe", 64'(got), 64'h0);
    end else begin
      want = exp_q.pop_front();
      r = req_q.pop_front();
      chk(got == want, r, "strobe mismatch {tag,value}", 64'(got), 64'(want));
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_we) begin
        observe(T_CMD, cmd_wdata);
        if (cmd_wdata[7:0] == 8'h65)
          chk(!flag, "R7", "level command while flag high", 64'(flag), 64'h0);
      end
      if (data_we)  observe(T_DATA, data_wdata);
      if (lvl_we)   observe(T_LVL, 32'(lvl_wdata));
      if (flag_set) observe(T_RAISE, 32'h0);
      chk(int'(cmd_we) + int'(data_we) + int'(lvl_we) + int'(flag_set) <= 1, "R7",
          "more than one strobe", 64'({cmd_we, data_we, lvl_we, flag_set}), 64'h0);
    end
  end

  task automatic send(input logic [1:0] kind, input logic [7:0] lvl, input logic [7:0] pipe,
                      input logic [7:0] bl, input logic [31:0] ramp);
    @(negedge clk);
    req_kind = kind; req_level = lvl; req_pipe = pipe; req_bl = bl; req_ramp = ramp;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic raise_flag();
    @(negedge clk); poke = 1'b1;
    @(negedge clk); poke = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy && exp_q.size() == 0, req, "sequence not drained",
        64'(exp_q.size()), 64'h0);
  endtask

  function automatic logic [31:0] lvl_cmd(input logic [7:0] l);
    return {8'h00, l, 8'h00, 8'h65};
  endfunction

  task automatic exp_backlight(input logic [7:0] bl, input logic [7:0] pipe,
                               input logic [31:0] ramp, input logic [16:0] ulvl);
    push(T_DATA, 32'hFFFF, "R4");
    push(T_CMD, {16'h0, pipe, 8'h66}, "R4");
    push(T_RAISE, 0, "R4");
    push(T_LVL, 32'(ulvl), "R5");
    push(T_DATA, (pipe == 0) ? 32'h0 : ramp, "R6");
    push(T_CMD, {16'h0, pipe, 8'h67}, "R4");
    push(T_RAISE, 0, "R4");
    send(2'd2, 8'h00, pipe, bl, ramp);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!busy && !err, "R1", "reset outputs", 64'({busy, err}), 64'h0);
    chk(!(cmd_we | data_we | lvl_we | flag_set), "R1", "strobe in reset",
        64'({cmd_we, data_we, lvl_we, flag_set}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 level request
    push(T_CMD, lvl_cmd(8'h2A), "R2"); push(T_RAISE, 0, "R2");
    send(2'd0, 8'h2A, 8'h03, 8'h00, 32'h0);
    wait_idle("R2");

    // R3 disable ignores level input
    push(T_CMD, lvl_cmd(8'hFF), "R3"); push(T_RAISE, 0, "R3");
    send(2'd1, 8'h11, 8'h00, 8'h00, 32'h0);
    wait_idle("R3");

    // R4 R5 backlight
    exp_backlight(8'hEF, 8'h02, 32'h1234, 17'h0EFF0);
    wait_idle("R4");
    // R5 R6 full scale on pipe 0
    exp_backlight(8'hFF, 8'h00, 32'hABCD, 17'h10000);
    wait_idle("R6");
    exp_backlight(8'h80, 8'h01, 32'h5, 17'h08081);
    wait_idle("R5");
    exp_backlight(8'h00, 8'h07, 32'h77, 17'h0);
    wait_idle("R5");

    // R7 level request while flag already up
    hold_len = 8;
    raise_flag();
    push(T_CMD, lvl_cmd(8'h40), "R2"); push(T_RAISE, 0, "R2");
    send(2'd0, 8'h40, 8'h00, 8'h00, 32'h0);
    chk(flag === 1'b1, "R7", "flag high during pre-wait", 64'(flag), 64'h1);
    wait_idle("R7");
    hold_len = 4;

    // R10 request while busy is dropped
    exp_backlight(8'h10, 8'h01, 32'h9, 17'h01010);
    chk(busy, "R10", "busy after accept", 64'(busy), 64'h1);
    send(2'd0, 8'h55, 8'h00, 8'h00, 32'h0);
    wait_idle("R10");

    // R10 reserved kind
    send(2'd3, 8'h33, 8'h01, 8'h22, 32'h1);
    chk(!busy, "R10", "reserved kind accepted", 64'(busy), 64'h0);
    wait_idle("R10");

    // R8 timeout in backlight wait
    stuck = 1'b1;
    push(T_DATA, 32'hFFFF, "R8"); push(T_CMD, {16'h0, 8'h04, 8'h66}, "R8");
    push(T_RAISE, 0, "R8");
    send(2'd2, 8'h00, 8'h04, 8'h60, 32'h3);
    n = 0;
    for (int i = 0; i < 500 && busy; i++) begin n++; @(negedge clk); end
    chk(n == LIMIT + 3, "R8", "busy cycles before abort", 64'(n), 64'(LIMIT + 3));
    chk(err, "R9", "error after timeout", 64'(err), 64'h1);
    wait_idle("R8");
    stuck = 1'b0;
    repeat (10) @(negedge clk);

    // R8 timeout in pre-write wait
    stuck = 1'b1;
    raise_flag();
    send(2'd0, 8'h12, 8'h00, 8'h00, 32'h0);
    n = 0;
    for (int i = 0; i < 500 && busy; i++) begin n++; @(negedge clk); end
    chk(n == LIMIT, "R8", "pre-wait polls before abort", 64'(n), 64'(LIMIT));
    wait_idle("R8");
    stuck = 1'b0;
    repeat (10) @(negedge clk);

    // R9 error survives a good request
    push(T_CMD, lvl_cmd(8'h07), "R2"); push(T_RAISE, 0, "R2");
    send(2'd0, 8'h07, 8'h00, 8'h00, 32'h0);
    wait_idle("R2");
    chk(err, "R9", "error sticky", 64'(err), 64'h1);

    // R9 R1 reset clears error
    rst_n = 1'b0;
    @(negedge clk);
    chk(!err && !busy, "R9", "reset clears error", 64'({err, busy}), 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule